// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

This block gathers a configurable number of interrupt request lines, up to 32, for one processor. Each line is fixed at elaboration as either rising-edge or level sensitive. A captured request sets a bit in a status word. A per-line mask gates that bit into a pending word. The controller merges the pending word into a single request output to the processor, qualified by two master gate bits.

Software reaches the controller through a small synchronous register port. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address and the current register state.

The enable mask can be written whole. It can also be changed atomically through two alias words, one that sets bits and one that clears them. A vector word returns the index of the lowest-numbered pending line.

Top module: `irqc_top`

## Requirements
- R1: After reset, the status, enable and master words read 0, the vector word reads 0xFFFFFFFF and `irq_o` is 0.
- R2: While the hardware-enable bit is 0, a write to offset 0x00 replaces the status word with the written data, ORed with any captured request. Bits at or above `N_SRC` always read 0.
- R3: A write to offset 0x08 replaces the enable word. A write to offset 0x10 sets the enable bits where the data has a 1. A write to offset 0x14 clears the enable bits where the data has a 1. In all three cases, bits at or above `N_SRC` read 0.
- R4: Offset 0x04 reads the status word ANDed with the enable word.
- R5: Offset 0x18 reads the index of the lowest-numbered set pending bit as a binary number. It reads 0xFFFFFFFF when no bit is pending.
- R6: `irq_o` is 1 exactly when master word bit 0 (master enable) is 1, bit 1 (hardware enable) is 1, and at least one pending bit is set.
- R7: A write to offset 0x0C clears each status bit where the data has a 1. All other status bits stay unchanged.
- R8: A line whose `EDGE_MASK` bit is 1 sets its status bit only in the cycle after it rises from 0 to 1. Once acknowledged, it stays clear while the line is held high.
- R9: A line whose `EDGE_MASK` bit is 0 sets its status bit on every clock edge where it is high. An acknowledge while it is high leaves the bit set. Once the line is low, an acknowledge clears the bit.
- R10: A write to offset 0x1C sets master enable to data bit 0. The hardware-enable bit becomes 1 when data bit 1 is 1, and it never returns to 0 after that. Once it is 1, writes to offset 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | N_SRC | Interrupt request lines |
| reg_addr_i | input | 5 | Register byte offset |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The bench uses an 8-line configuration with lines 0 to 3 edge sensitive and lines 4 to 7 level sensitive.

Before hardware enable is set, it loads every one of the 256 status patterns by software write. Each pattern is crossed with eight enable masks: empty, full, single low bit, single high bit, and the alternating and nibble masks. This separates a wrong AND in the pending word from a wrong priority direction in the vector.

Separate sequences hold an edge line and a level line high across an acknowledge. This tells a rising-edge capture apart from a level capture, and a permanent clear apart from a transient one. Writes to the master word then show that each gate bit alone blocks the output and that hardware enable cannot be withdrawn.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_EN     = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_SETEN  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CLREN  = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_VEC    = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_MASTER = 5'h1C;

    localparam int BIT_ME  = 0;
    localparam int BIT_HIE = 1;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] enable;
        logic              me;
        logic              hie;
    } regs_t;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] set_o
);
    logic [N_SRC-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            assign set_o[i] = src_i[i] & ~prev_q[i];
            // R8: a rising edge cannot be reported on two consecutive cycles
            a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
                set_o[i] |=> !set_o[i]);
        end else begin : g_level
            assign set_o[i] = src_i[i];
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N_SRC = 32,
    parameter int OUT_W = 32
) (
    input  logic [N_SRC-1:0] req_i,
    output logic [OUT_W-1:0] idx_o
);
    always_comb begin
        idx_o = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = OUT_W'(i);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src_i,
    input  logic [4:0]        reg_addr_i,
    input  logic              reg_we_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam logic [WORD_W-1:0] VALID_MASK =
        (N_SRC >= WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << N_SRC) - WORD_W'(1));

    regs_t r_d, r_q;
    logic [N_SRC-1:0]  set_w;
    logic [WORD_W-1:0] set_ext;
    logic [WORD_W-1:0] pending_w;
    logic [WORD_W-1:0] vec_w;
    logic              ack_wr;

    irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (irq_src_i),
        .set_o (set_w)
    );

    always_comb begin
        set_ext = '0;
        set_ext[N_SRC-1:0] = set_w;
    end

    assign pending_w = r_q.status & r_q.enable;

    irqc_prio #(.N_SRC(N_SRC), .OUT_W(WORD_W)) u_prio (
        .req_i (pending_w[N_SRC-1:0]),
        .idx_o (vec_w)
    );

    assign ack_wr = reg_we_i && (reg_addr_i == OFF_ACK);

    always_comb begin
        r_d = r_q;
        if (reg_we_i) begin
            case (reg_addr_i)
                OFF_STAT:   if (!r_q.hie) r_d.status = reg_wdata_i;
                OFF_EN:     r_d.enable = reg_wdata_i;
                OFF_ACK:    r_d.status = r_q.status & ~reg_wdata_i;
                OFF_SETEN:  r_d.enable = r_q.enable | reg_wdata_i;
                OFF_CLREN:  r_d.enable = r_q.enable & ~reg_wdata_i;
                OFF_MASTER: begin
                    r_d.me  = reg_wdata_i[BIT_ME];
                    r_d.hie = r_q.hie | reg_wdata_i[BIT_HIE];
                end
                default: ;
            endcase
        end
        r_d.status = (r_d.status | set_ext) & VALID_MASK;
        r_d.enable = r_d.enable & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr_i)
            OFF_STAT:   reg_rdata_o = r_q.status;
            OFF_PEND:   reg_rdata_o = pending_w;
            OFF_EN:     reg_rdata_o = r_q.enable;
            OFF_VEC:    reg_rdata_o = vec_w;
            OFF_MASTER: reg_rdata_o = {30'b0, r_q.hie, r_q.me};
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o = r_q.me & r_q.hie & (|pending_w);

    // R5: a vector other than all ones names a pending line
    a_r5_vector_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_w != '1) |-> pending_w[vec_w[4:0]]);

    // R10: hardware enable never drops once set
    a_r10_hie_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hie |=> r_q.hie);

    // R10: with hardware enable set, status moves only by capture or acknowledge
    a_r10_status_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hie && !ack_wr && (set_w == '0)) |=> $stable(r_q.status));

    for (genvar i = 0; i < N_SRC; i++) begin : g_lvl_chk
        if (!EDGE_MASK[i]) begin : g_chk
            // R9: a high level line is latched on the next edge
            a_r9_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
                irq_src_i[i] |=> r_q.status[i]);
        end
    end
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
    localparam int NS = 8;
    localparam logic [31:0] EM = 32'h0000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    irqc_top #(.N_SRC(NS), .EDGE_MASK(EM)) uut (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src),
        .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [31:0] lowest(input logic [31:0] p);
        for (int i = 31; i >= 0; i--) ;
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] emasks [8];
        emasks = '{32'h00, 32'hFF, 32'h01, 32'h80, 32'hAA, 32'h55, 32'hF0, 32'h0F};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); chk("R1 status", v, 0);
        rd(5'h08, v); chk("R1 enable", v, 0);
        rd(5'h1C, v); chk("R1 master", v, 0);
        rd(5'h18, v); chk("R1 vector", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq}, 0);

        wr(5'h1C, 32'h1);
        // R2 R4 R5 R6 sweep while hardware enable is 0
        for (int s = 0; s < 256; s++) begin
            for (int k = 0; k < 8; k++) begin
                wr(5'h00, 32'hFFFF_FF00 | 32'(s));
                wr(5'h08, emasks[k]);
                rd(5'h00, v); chk("R2 status write", v, 32'(s));
                rd(5'h04, v); chk("R4 pending", v, 32'(s) & emasks[k]);
                rd(5'h18, v); chk("R5 vector", v, lowest(32'(s) & emasks[k]));
                chk("R6 irq blocked by hie", {31'b0, irq}, 0);
            end
        end

        // R3 enable aliases
        wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); chk("R3 enable upper zero", v, 32'hFF);
        wr(5'h08, 32'h0F);
        wr(5'h10, 32'h30); rd(5'h08, v); chk("R3 set-enable", v, 32'h3F);
        wr(5'h14, 32'h05); rd(5'h08, v); chk("R3 clear-enable", v, 32'h3A);

        // R7 acknowledge
        wr(5'h00, 32'hFF);
        wr(5'h0C, 32'h81); rd(5'h00, v); chk("R7 ack partial", v, 32'h7E);
        wr(5'h0C, 32'hFFFF_FFFF); rd(5'h00, v); chk("R7 ack all", v, 0);

        // R6 R10 master gates
        wr(5'h00, 32'h10); wr(5'h08, 32'h10);
        chk("R6 irq hie off", {31'b0, irq}, 0);
        wr(5'h1C, 32'h3); #1 chk("R6 irq on", {31'b0, irq}, 1);
        wr(5'h1C, 32'h1); rd(5'h1C, v); chk("R10 hie sticky", v, 32'h3);
        chk("R6 irq still on", {31'b0, irq}, 1);
        wr(5'h1C, 32'h2); rd(5'h1C, v); chk("R10 me cleared", v, 32'h2);
        chk("R6 irq me off", {31'b0, irq}, 0);
        wr(5'h1C, 32'h3);
        wr(5'h00, 32'h00); rd(5'h00, v); chk("R10 status write ignored", v, 32'h10);
        wr(5'h0C, 32'h10); rd(5'h00, v); chk("R7 ack after hie", v, 0);

        // R8 edge line 2
        wr(5'h08, 32'hFF);
        @(negedge clk); src[2] = 1'b1;
        rd(5'h00, v); chk("R8 edge captured", v, 32'h04);
        rd(5'h18, v); chk("R5 vector edge", v, 2);
        chk("R6 irq edge", {31'b0, irq}, 1);
        wr(5'h0C, 32'h04);
        repeat (3) @(negedge clk);
        rd(5'h00, v); chk("R8 held high stays clear", v, 0);
        @(negedge clk); src[2] = 1'b0;
        @(negedge clk); src[2] = 1'b1;
        rd(5'h00, v); chk("R8 second edge", v, 32'h04);
        src[2] = 1'b0;
        wr(5'h0C, 32'h04);

        // R9 level line 5
        @(negedge clk); src[5] = 1'b1;
        rd(5'h00, v); chk("R9 level captured", v, 32'h20);
        wr(5'h0C, 32'h20);
        rd(5'h00, v); chk("R9 ack while high", v, 32'h20);
        @(negedge clk); src[5] = 1'b0;
        wr(5'h0C, 32'h20);
        rd(5'h00, v); chk("R9 ack after low", v, 0);
        rd(5'h18, v); chk("R5 vector empty", v, 32'hFFFF_FFFF);
        chk("R6 irq none", {31'b0, irq}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule